// File: doc/BRIEF.md
# Serial-Bus Peripheral Interrupt Register Block

This block sits between a serial bus peripheral and a 32-bit register port. It gathers eight interrupt sources into a sticky status register, masks each one with its own enable bit, and gates the combined result with a single global enable bit before driving one interrupt line. Writing a one to a status bit inverts that bit rather than clearing it. Software that wants to acknowledge an interrupt must therefore read the status and write back only the bits it found set.

A soft-reset register sits beside the interrupt registers. Writing the key value to it starts a reset pulse of fixed length toward the peripheral, and the block clears its own registers while the pulse is high. Any other value written there does nothing. Register access uses a word index: the byte offset divided by four.

Top module: `bus_irq_regs`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` and `prst_o` are low. Registers are selected by word index: global enable 7 (byte 0x01C), status 8 (byte 0x020), enable 10 (byte 0x028), soft reset 16 (byte 0x040). Read data appears in the cycle after the clock edge that samples `rd_en_i`.
- R2: A write to the status register inverts every status bit whose `wdata_i` bit is 1. Bits written with 0 keep their value.
- R3: While `src_i[k]` is high at a clock edge, status bit k is set at that edge. This holds even when the same edge carries a toggle write to bit k.
- R4: The enable register holds 8 bits in `wdata_i[7:0]`. The bit positions are shared with the status register: 0 arbitration lost, 1 transmit error, 2 transmit queue empty, 3 receive queue full, 4 bus idle, 5 selected as target, 6 deselected as target, 7 transmit queue half empty.
- R5: `irq_o` is registered. It is high in the cycle after an edge at which global enable bit 31 is 1 and at least one status bit has its enable bit set. Otherwise it is low.
- R6: A write of exactly 32'h0000000A to the soft-reset register starts a reset pulse. A write of any other value has no effect on `prst_o` or on any register.
- R7: `prst_o` stays high for exactly RST_CYCLES clock cycles after the key write, and then returns low.
- R8: At every edge where `prst_o` is high, the status, enable and global-enable registers are forced to 0. Register writes and source inputs have no effect at those edges.
- R9: The global-enable register reads back only bit 31. Reads of the soft-reset register or of any unmapped index return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Word index of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data, 0 when no read |
| src_i | input | NUM_SRC | Interrupt source inputs, active high |
| irq_o | output | 1 | Registered interrupt request |
| prst_o | output | 1 | Peripheral reset pulse |

## Verification
The checks assume that `wr_en_i` and `rd_en_i` are never both high in one cycle. They also assume that every source input is active high and held for at least one whole clock cycle. The stimulus drives inputs only on the falling edge and uses a single strobe per cycle. Sources are pulsed for exactly one cycle, so the effect of one edge can be told apart from the effect of a level held over several edges. The test of sources arriving during a reset pulse releases its source well before the pulse ends. That keeps the check that the registers are cleared independent of when the stimulus happens to land.

// File: rtl/bus_irq_pkg.sv
package bus_irq_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned IDX_GIE  = 7;
  localparam int unsigned IDX_STAT = 8;
  localparam int unsigned IDX_EN   = 10;
  localparam int unsigned IDX_SRST = 16;
  localparam int unsigned GIE_BIT  = 31;
  localparam logic [DATA_W-1:0] SRST_KEY = 32'h0000_000A;

  typedef enum logic [2:0] {
    SRC_ARB_LOST  = 3'd0,
    SRC_TX_ERR    = 3'd1,
    SRC_TXQ_EMPTY = 3'd2,
    SRC_RXQ_FULL  = 3'd3,
    SRC_BUS_IDLE  = 3'd4,
    SRC_SEL       = 3'd5,
    SRC_DESEL     = 3'd6,
    SRC_TXQ_HALF  = 3'd7
  } src_idx_e;

  typedef struct packed {
    logic gie;
    logic stat;
    logic en;
    logic srst;
  } reg_sel_t;
endpackage

// File: rtl/bus_irq_access.sv
module bus_irq_access
  import bus_irq_pkg::*;
#(
  parameter int unsigned ADDR_W  = 6,
  parameter int unsigned NUM_SRC = 8
) (
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NUM_SRC-1:0] stat_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic              gie_i,
  output reg_sel_t          wsel_o,
  output logic [DATA_W-1:0] rdata_o
);
  reg_sel_t hit;

  always_comb begin
    hit.gie  = (addr_i == ADDR_W'(IDX_GIE));
    hit.stat = (addr_i == ADDR_W'(IDX_STAT));
    hit.en   = (addr_i == ADDR_W'(IDX_EN));
    hit.srst = (addr_i == ADDR_W'(IDX_SRST));
  end

  always_comb begin
    wsel_o.gie  = wr_en_i & hit.gie;
    wsel_o.stat = wr_en_i & hit.stat;
    wsel_o.en   = wr_en_i & hit.en;
    wsel_o.srst = wr_en_i & hit.srst;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      if (hit.gie)  rdata_o[GIE_BIT]     = gie_i;
      if (hit.stat) rdata_o[NUM_SRC-1:0] = stat_i;
      if (hit.en)   rdata_o[NUM_SRC-1:0] = en_i;
    end
  end
endmodule

// File: rtl/bus_irq_status.sv
module bus_irq_status #(
  parameter int unsigned NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr_i,
  input  logic               tog_we_i,
  input  logic [NUM_SRC-1:0] tog_bits_i,
  input  logic [NUM_SRC-1:0] src_i,
  output logic [NUM_SRC-1:0] stat_o
);
  for (genvar k = 0; k < NUM_SRC; k++) begin : g_bit
    logic bit_q;
    logic flip;
    assign flip = tog_we_i & tog_bits_i[k];
    always_ff @(posedge clk) begin
      if (rst || clr_i) bit_q <= 1'b0;
      else              bit_q <= (bit_q ^ flip) | src_i[k];
    end
    assign stat_o[k] = bit_q;
  end
endmodule

// File: rtl/bus_irq_softrst.sv
module bus_irq_softrst
  import bus_irq_pkg::*;
#(
  parameter int unsigned RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              pulse_o
);
  localparam int unsigned CNT_W = $clog2(RST_CYCLES + 1);
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             pulse_q;

  always_comb begin
    cnt_n = cnt_q;
    if (cnt_q != '0)                           cnt_n = cnt_q - 1'b1;
    else if (we_i && (wdata_i == SRST_KEY))    cnt_n = CNT_W'(RST_CYCLES);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      pulse_q <= (cnt_n != '0);
    end
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/bus_irq_regs.sv
module bus_irq_regs
  import bus_irq_pkg::*;
#(
  parameter int unsigned ADDR_W     = 6,
  parameter int unsigned NUM_SRC    = 8,
  parameter int unsigned RST_CYCLES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  input  logic [NUM_SRC-1:0] src_i,
  output logic               irq_o,
  output logic               prst_o
);
  reg_sel_t           wsel;
  logic [NUM_SRC-1:0] stat_q;
  logic [NUM_SRC-1:0] en_q;
  logic               gie_q;
  logic               pulse;
  logic [DATA_W-1:0]  rd_mux;
  logic [DATA_W-1:0]  rdata_q;
  logic               irq_q;

  bus_irq_access #(.ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC)) u_access (
    .wr_en_i (wr_en_i),
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .stat_i  (stat_q),
    .en_i    (en_q),
    .gie_i   (gie_q),
    .wsel_o  (wsel),
    .rdata_o (rd_mux)
  );

  bus_irq_status #(.NUM_SRC(NUM_SRC)) u_status (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (pulse),
    .tog_we_i   (wsel.stat),
    .tog_bits_i (wdata_i[NUM_SRC-1:0]),
    .src_i      (src_i),
    .stat_o     (stat_q)
  );

  bus_irq_softrst #(.RST_CYCLES(RST_CYCLES)) u_softrst (
    .clk     (clk),
    .rst     (rst),
    .we_i    (wsel.srst),
    .wdata_i (wdata_i),
    .pulse_o (pulse)
  );

  always_ff @(posedge clk) begin
    if (rst || pulse) begin
      en_q  <= '0;
      gie_q <= 1'b0;
    end else begin
      if (wsel.en)  en_q  <= wdata_i[NUM_SRC-1:0];
      if (wsel.gie) gie_q <= wdata_i[GIE_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      rdata_q <= rd_mux;
      irq_q   <= gie_q & (|(stat_q & en_q));
    end
  end

  assign rdata_o = rdata_q;
  assign irq_o   = irq_q;
  assign prst_o  = pulse;
endmodule

// File: rtl/bus_irq_regs_chk.sv
module bus_irq_regs_chk #(
  parameter int unsigned ADDR_W     = 6,
  parameter int unsigned NUM_SRC    = 8,
  parameter int unsigned RST_CYCLES = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [31:0]        wdata_i,
  input logic [NUM_SRC-1:0] src_i,
  input logic [NUM_SRC-1:0] stat_q,
  input logic [NUM_SRC-1:0] en_q,
  input logic               gie_q,
  input logic               irq_o,
  input logic               prst_o
);
  localparam int unsigned WIN_W = $clog2(RST_CYCLES + 2) + 1;
  logic [WIN_W-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst)         hi_cnt <= '0;
    else if (prst_o) hi_cnt <= hi_cnt + 1'b1;
    else             hi_cnt <= '0;
  end

  logic stat_wr;
  assign stat_wr = wr_en_i && (addr_i == ADDR_W'(8));

  // R2: toggle with no source and no reset pulse
  p_toggle_r2: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && !prst_o && src_i == '0) |=>
      (stat_q == ($past(stat_q) ^ $past(wdata_i[NUM_SRC-1:0]))));

  // R3: a source always lands
  p_src_wins_r3: assert property (@(posedge clk) disable iff (rst)
    (!prst_o && src_i != '0) |=> ((stat_q & $past(src_i)) == $past(src_i)));

  // R5: masked request
  p_irq_masked_r5: assert property (@(posedge clk) disable iff (rst)
    !gie_q |=> !irq_o);
  p_irq_raised_r5: assert property (@(posedge clk) disable iff (rst)
    (gie_q && ((stat_q & en_q) != '0)) |=> irq_o);

  // R6: wrong key does nothing
  p_bad_key_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && addr_i == ADDR_W'(16) && wdata_i != 32'h0000000A && !prst_o)
      |=> !prst_o);

  // R7: pulse length
  p_pulse_len_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(prst_o) |-> (hi_cnt == WIN_W'(RST_CYCLES)));
  p_pulse_max_r7: assert property (@(posedge clk) disable iff (rst)
    (hi_cnt <= WIN_W'(RST_CYCLES)));

  // R8: registers cleared under the pulse
  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    prst_o |=> (stat_q == '0 && en_q == '0 && !gie_q));
endmodule

bind bus_irq_regs bus_irq_regs_chk #(
  .ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC), .RST_CYCLES(RST_CYCLES)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .src_i   (src_i),
  .stat_q  (stat_q),
  .en_q    (en_q),
  .gie_q   (gie_q),
  .irq_o   (irq_o),
  .prst_o  (prst_o)
);

// File: tb/sim_bus_irq_regs.sv
`timescale 1ns/1ps
module sim_bus_irq_regs;
  localparam int unsigned AW  = 6;
  localparam int unsigned NS  = 8;
  localparam int unsigned RC  = 4;
  localparam logic [AW-1:0] A_GIE  = 6'd7;
  localparam logic [AW-1:0] A_STAT = 6'd8;
  localparam logic [AW-1:0] A_EN   = 6'd10;
  localparam logic [AW-1:0] A_SRST = 6'd16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NS-1:0] src = '0;
  logic          irq, prst;
  int            checks = 0, errors = 0;
  bit            done = 1'b0;

  always #4 clk = ~clk;

  bus_irq_regs #(.ADDR_W(AW), .NUM_SRC(NS), .RST_CYCLES(RC)) u0 (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .src_i(src), .irq_o(irq), .prst_o(prst)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic pulse_src(input logic [NS-1:0] s);
    @(negedge clk); src = s;
    @(negedge clk); src = '0;
  endtask

  task automatic wait_pulse_end();
    for (int i = 0; i < 50 && prst; i++) @(negedge clk);
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    chk("R1 prst after reset", {31'd0, prst}, 32'd0);
    rd(A_GIE, d);  chk("R1 gie reset", d, 32'd0);
    rd(A_STAT, d); chk("R1 stat reset", d, 32'd0);
    rd(A_EN, d);   chk("R1 en reset", d, 32'd0);
  endtask

  task automatic t_toggle();
    logic [31:0] d;
    pulse_src(8'b0000_0101);
    rd(A_STAT, d); chk("R3 sources set bits", d, 32'h05);
    wr(A_STAT, 32'h01);
    rd(A_STAT, d); chk("R2 toggle clears set bit", d, 32'h04);
    wr(A_STAT, 32'h12);
    rd(A_STAT, d); chk("R2 toggle sets clear bits", d, 32'h16);
    wr(A_STAT, 32'h16);
    rd(A_STAT, d); chk("R2 write-back clears all", d, 32'h00);
  endtask

  task automatic t_same_cycle();
    logic [31:0] d;
    pulse_src(8'h80);
    @(negedge clk); wr_en = 1'b1; addr = A_STAT; wdata = 32'h80; src = 8'h80;
    @(negedge clk); wr_en = 1'b0; wdata = '0; src = '0;
    rd(A_STAT, d); chk("R3 source beats toggle", d, 32'h80);
    wr(A_STAT, 32'h80);
  endtask

  task automatic t_enable_irq();
    logic [31:0] d;
    wr(A_EN, 32'hFFFF_FF08);
    rd(A_EN, d); chk("R4 enable low byte only", d, 32'h08);
    pulse_src(8'h08);
    @(negedge clk);
    chk("R5 no irq without gie", {31'd0, irq}, 32'd0);
    wr(A_GIE, 32'h8000_0000);
    @(negedge clk);
    chk("R5 irq with gie", {31'd0, irq}, 32'd1);
    rd(A_GIE, d); chk("R9 gie reads bit31", d, 32'h8000_0000);
    wr(A_EN, 32'h04);
    @(negedge clk);
    chk("R5 irq off when masked", {31'd0, irq}, 32'd0);
    wr(A_EN, 32'h08);
    wr(A_STAT, 32'h08);
    @(negedge clk);
    chk("R5 irq off after ack", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_readmisc();
    logic [31:0] d;
    wr(A_GIE, 32'hFFFF_FFFF);
    rd(A_GIE, d);  chk("R9 gie other bits 0", d, 32'h8000_0000);
    rd(A_SRST, d); chk("R9 srst reads 0", d, 32'd0);
    rd(6'd3, d);   chk("R9 unmapped reads 0", d, 32'd0);
  endtask

  task automatic t_bad_key();
    logic [31:0] d;
    wr(A_SRST, 32'h0000_000B);
    chk("R6 wrong key no pulse", {31'd0, prst}, 32'd0);
    wr(A_SRST, 32'h0000_010A);
    chk("R6 wide wrong key no pulse", {31'd0, prst}, 32'd0);
    rd(A_EN, d); chk("R6 enable kept", d, 32'h08);
  endtask

  task automatic t_soft_reset();
    logic [31:0] d;
    int n;
    pulse_src(8'h21);
    wr(A_SRST, 32'h0000_000A);
    chk("R6 key starts pulse", {31'd0, prst}, 32'd1);
    n = 0;
    for (int i = 0; i < 50 && prst; i++) begin
      n++;
      if (i == 0) begin wr_en = 1'b1; addr = A_EN; wdata = 32'hFF; src = 8'hFF; end
      else begin wr_en = 1'b0; src = '0; end
      @(negedge clk);
    end
    wr_en = 1'b0; src = '0;
    chk("R7 pulse length", n, RC);
    rd(A_STAT, d); chk("R8 stat cleared", d, 32'd0);
    rd(A_EN, d);   chk("R8 en cleared, write ignored", d, 32'd0);
    rd(A_GIE, d);  chk("R8 gie cleared", d, 32'd0);
    chk("R8 irq low after pulse", {31'd0, irq}, 32'd0);
    wait_pulse_end();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_toggle();
    t_same_cycle();
    t_enable_irq();
    t_readmisc();
    t_bad_key();
    t_soft_reset();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule